// File: doc/BRIEF.md
# Double-Buffered Trigger Reload Controller

This block holds the configuration of a trigger-generation unit as two copies. Software writes a shadow copy through a small register port. The active copy drives the trigger outputs. The shadow copy is moved into the active copy only on a master reload strobe, and only if software has armed the reload by setting a commit bit. After the copy, the commit bit clears by itself, so each armed reload happens once.

Around this exchange the block does four more things. It can raise a DMA request for each reload that takes place. It flags two programming mistakes: a reload strobe that arrives while software is still rewriting the shadow copy, and too many events between two strobes when the unit is in sequential mode. It masks the trigger request bus with the active configuration and can force every trigger output low. A module-off bit freezes all internal, non-register state, while the register port keeps working.

Top module: `trig_reload_ctrl`

## Requirements
- R1: A write to shadow word i (address 4+i) can be read back at that address. It leaves `cfg_active` unchanged until a reload takes place. Address 8+i returns active word i.
- R2: When `mrs` is high, CTRL bit 0 (commit) is 1 and CTRL bit 2 (module off) is 0, `cfg_active` holds the shadow copy from the next cycle on. CTRL bit 0 then reads back 0.
- R3: An `mrs` pulse while commit is 0 leaves `cfg_active` unchanged.
- R4: A shadow write marks an update as in progress, and so does writing CTRL bit 0 as 0 while it was 1. Writing CTRL bit 0 as 1 ends the update. An `mrs` during an update sets ERR bit 0 if ENA bit 0 (address 1) is 1.
- R5: In sequential mode (CTRL bit 3), the event count restarts at each `mrs`. The ninth event before the next `mrs` sets ERR bit 1 if ENA bit 1 is 1. Eight events do not. Outside sequential mode, events never set it.
- R6: ERR flags (address 2) are sticky. Writing 1 to a flag clears it, and writing 0 has no effect. `err_irq[k]` is ERR bit k AND ENA bit k.
- R7: A reload with ENA bit 2 set raises `dma_req` in the next cycle. It stays high until `dma_ack`, and then drops in the following cycle. An `mrs` that performs no reload raises no request.
- R8: `trig_out` is `trig_req` AND the low bits of active word 0. It is all zero while CTRL bit 1 (output disable) is 1.
- R9: While CTRL bit 2 is 1, `mrs` and `evt` have no effect: no reload, no count change, no flag. Register writes are still accepted.
- R10: In sequential mode, an `evt` in the same cycle as `mrs` counts as the first event of the new window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| mrs | input | 1 | Master reload strobe |
| evt | input | 1 | Event strobe, counted in sequential mode |
| trig_req | input | 8 | Trigger requests from the scheduler |
| trig_out | output | 8 | Gated trigger outputs |
| cfg_active | output | 64 | Active configuration, word i at bits 16i+15:16i |
| dma_req | output | 1 | DMA request raised on reload |
| dma_ack | input | 1 | DMA acknowledge |
| err_irq | output | 2 | Enabled error flags: bit 0 reload-during-update, bit 1 event overrun |

## Verification
The assertions assume that all inputs are synchronous to `clk` and stable across each rising edge. They also assume `dma_ack` is a level that the request logic may act on in the cycle it is seen. Under these assumptions, the hold and drop rules of the request are exact properties. The stimulus changes every input on the falling edge only. It acknowledges only a request that is already high, and it writes at most one register per cycle. This keeps reload, error and counter behaviour determined by a single sampling edge.

// File: rtl/trig_reload_pkg.sv
package trig_reload_pkg;
  localparam int A_CTRL = 0;
  localparam int A_ENA  = 1;
  localparam int A_ERR  = 2;
  localparam int A_SHD  = 4;
  localparam int A_ACT  = 8;

  typedef struct packed {
    logic seq_mode;
    logic mod_off;
    logic out_dis;
    logic commit;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
  import trig_reload_pkg::*;
#(
  parameter int CFG_W   = 16,
  parameter int NUM_CFG = 4,
  parameter int ADDR_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CFG_W-1:0]         wdata,
  input  logic                     mrs_live,
  output ctrl_t                    ctrl_o,
  output logic [NUM_CFG*CFG_W-1:0] shadow_o,
  output logic [NUM_CFG*CFG_W-1:0] active_o,
  output logic                     reload_o,
  output logic                     busy_hit_o
);
  localparam int TOT_W = NUM_CFG * CFG_W;

  ctrl_t ctrl_q;
  logic  busy_q;
  logic  ctrl_wr;
  logic  shd_wr_any;
  logic [NUM_CFG-1:0] shd_wr;

  assign ctrl_wr    = we && (addr == ADDR_W'(A_CTRL));
  assign reload_o   = mrs_live && ctrl_q.commit;
  assign busy_hit_o = mrs_live && busy_q;
  assign shd_wr_any = |shd_wr;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CFG; gi++) begin : g_word
      assign shd_wr[gi] = we && (addr == ADDR_W'(A_SHD + gi));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          shadow_o[gi*CFG_W +: CFG_W] <= '0;
        end else if (shd_wr[gi]) begin
          shadow_o[gi*CFG_W +: CFG_W] <= wdata;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          active_o[gi*CFG_W +: CFG_W] <= '0;
        end else if (reload_o) begin
          active_o[gi*CFG_W +: CFG_W] <= shadow_o[gi*CFG_W +: CFG_W];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      end else if (reload_o) begin
        ctrl_q.commit <= 1'b0;
      end
      if (ctrl_wr && wdata[0]) begin
        busy_q <= 1'b0;
      end else if (shd_wr_any || (ctrl_wr && !wdata[0] && ctrl_q.commit)) begin
        busy_q <= 1'b1;
      end
    end
  end

  assign ctrl_o = ctrl_q;

  // R2
  reload_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_o |=> active_o == $past(shadow_o));
  // R2
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_o && !ctrl_wr) |=> !ctrl_q.commit);
  // R3
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_o |=> $stable(active_o));
  // R4
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[0]) |=> !busy_q);

  logic unused_w;
  assign unused_w = ^TOT_W;
endmodule

// File: rtl/trig_evt_monitor.sv
module trig_evt_monitor #(
  parameter int CNT_W     = 4,
  parameter int OVR_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic seq_mode,
  input  logic mrs,
  input  logic evt,
  output logic ovr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIMIT   = CNT_W'(OVR_LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic             ev_seq;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    return (c == CNT_MAX) ? c : c + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic restart,
                                                  input logic ev);
    if (restart) return ev ? CNT_W'(1) : '0;
    if (ev)      return sat_inc(c);
    return c;
  endfunction

  assign ev_seq = evt && seq_mode;
  assign ovr_o  = enable && ev_seq && !mrs && (cnt_q >= LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (enable) begin
      cnt_q <= next_count(cnt_q, mrs, ev_seq);
    end
  end

  // R5
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mrs) |=> cnt_q <= CNT_W'(1));
  // R9
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> $stable(cnt_q));
  // R10
  cnt_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mrs && ev_seq) |=> cnt_q == CNT_W'(1));
endmodule

// File: rtl/trig_dma_gate.sv
module trig_dma_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic reload,
  input  logic dma_en,
  input  logic ack,
  output logic req_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o <= 1'b0;
    end else if (!hold) begin
      if (req_o && ack) begin
        req_o <= 1'b0;
      end else if (!req_o && reload && dma_en) begin
        req_o <= 1'b1;
      end
    end
  end

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack) |=> req_o);
  // R7
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && ack && !hold) |=> !req_o);
  // R7
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_o) |-> $past(reload && dma_en));
endmodule

// File: rtl/trig_reload_ctrl.sv
module trig_reload_ctrl
  import trig_reload_pkg::*;
#(
  parameter int CFG_W     = 16,
  parameter int NUM_CFG   = 4,
  parameter int ADDR_W    = 4,
  parameter int NUM_TRIG  = 8,
  parameter int CNT_W     = 4,
  parameter int OVR_LIMIT = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [CFG_W-1:0]         reg_wdata,
  output logic [CFG_W-1:0]         reg_rdata,
  input  logic                     mrs,
  input  logic                     evt,
  input  logic [NUM_TRIG-1:0]      trig_req,
  output logic [NUM_TRIG-1:0]      trig_out,
  output logic [NUM_CFG*CFG_W-1:0] cfg_active,
  output logic                     dma_req,
  input  logic                     dma_ack,
  output logic [1:0]               err_irq
);
  localparam int ERR_N = 2;
  localparam int ENA_W = 3;

  ctrl_t                    ctrl;
  logic [NUM_CFG*CFG_W-1:0] shadow;
  logic                     mrs_live;
  logic                     reload_ev;
  logic                     busy_hit_ev;
  logic                     ovr_ev;
  logic [ENA_W-1:0]         ena_q;
  logic [ERR_N-1:0]         err_q;
  logic [ERR_N-1:0]         err_set;
  logic [ERR_N-1:0]         err_clr;

  assign mrs_live = mrs && !ctrl.mod_off;

  trig_cfg_bank #(.CFG_W(CFG_W), .NUM_CFG(NUM_CFG), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .mrs_live(mrs_live), .ctrl_o(ctrl), .shadow_o(shadow), .active_o(cfg_active),
    .reload_o(reload_ev), .busy_hit_o(busy_hit_ev)
  );

  trig_evt_monitor #(.CNT_W(CNT_W), .OVR_LIMIT(OVR_LIMIT)) u_evt (
    .clk(clk), .rst_n(rst_n), .enable(!ctrl.mod_off), .seq_mode(ctrl.seq_mode),
    .mrs(mrs), .evt(evt), .ovr_o(ovr_ev)
  );

  trig_dma_gate u_dma (
    .clk(clk), .rst_n(rst_n), .hold(ctrl.mod_off), .reload(reload_ev),
    .dma_en(ena_q[2]), .ack(dma_ack), .req_o(dma_req)
  );

  assign err_set = {ovr_ev && ena_q[1], busy_hit_ev && ena_q[0]};
  assign err_clr = (reg_we && reg_addr == ADDR_W'(A_ERR)) ? reg_wdata[ERR_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
      err_q <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_W'(A_ENA)) ena_q <= reg_wdata[ENA_W-1:0];
      err_q <= (err_q & ~err_clr) | err_set;
    end
  end

  assign err_irq  = err_q & ena_q[ERR_N-1:0];
  assign trig_out = ctrl.out_dis ? '0 : (trig_req & cfg_active[NUM_TRIG-1:0]);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) reg_rdata = CFG_W'(ctrl);
    if (reg_addr == ADDR_W'(A_ENA))  reg_rdata = CFG_W'(ena_q);
    if (reg_addr == ADDR_W'(A_ERR))  reg_rdata = CFG_W'(err_q);
    for (int i = 0; i < NUM_CFG; i++) begin
      if (reg_addr == ADDR_W'(A_SHD + i)) reg_rdata = shadow[i*CFG_W +: CFG_W];
      if (reg_addr == ADDR_W'(A_ACT + i)) reg_rdata = cfg_active[i*CFG_W +: CFG_W];
    end
  end

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[0] && !err_clr[0]) |=> err_q[0]);
  // R6
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q[1] && !err_clr[1]) |=> err_q[1]);
  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.mod_off && !err_q[0]) |=> !err_q[0]);
endmodule

// File: tb/tb_trig_reload_ctrl.sv
module tb_trig_reload_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        mrs = 1'b0;
  logic        evt = 1'b0;
  logic [7:0]  trig_req = '0;
  logic [7:0]  trig_out;
  logic [63:0] cfg_active;
  logic        dma_req;
  logic        dma_ack = 1'b0;
  logic [1:0]  err_irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trig_reload_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mrs(mrs), .evt(evt),
    .trig_req(trig_req), .trig_out(trig_out), .cfg_active(cfg_active),
    .dma_req(dma_req), .dma_ack(dma_ack), .err_irq(err_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [15:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic pulse_mrs(input logic with_evt);
    @(negedge clk);
    mrs = 1'b1; evt = with_evt;
    @(negedge clk);
    mrs = 1'b0; evt = 1'b0;
  endtask

  task automatic events(input int n);
    @(negedge clk);
    evt = 1'b1;
    repeat (n) @(negedge clk);
    evt = 1'b0;
  endtask

  task automatic t_reset;
    trig_req = 8'hFF;
    #1;
    chk("R1 reset active", cfg_active, 64'h0);
    chk("R8 reset trig", 64'(trig_out), 64'h0);
    chk("R7 reset dma", 64'(dma_req), 64'h0);
    rd_chk("R2 reset ctrl", 4'd0, 16'h0);
    rd_chk("R6 reset err", 4'd2, 16'h0);
  endtask

  task automatic t_shadow;
    wr(4'd4, 16'h00A5);
    wr(4'd5, 16'h1234);
    chk("R1 active untouched", cfg_active, 64'h0);
    rd_chk("R1 shadow readback", 4'd4, 16'h00A5);
    rd_chk("R1 active readback", 4'd8, 16'h0000);
  endtask

  task automatic t_reload;
    wr(4'd0, 16'h0001);
    pulse_mrs(1'b0);
    chk("R2 reload copy", cfg_active, 64'h0000_0000_1234_00A5);
    rd_chk("R2 commit cleared", 4'd0, 16'h0000);
    #1;
    chk("R8 trig masked", 64'(trig_out), 64'hA5);
    wr(4'd4, 16'h000F);
    pulse_mrs(1'b0);
    chk("R3 no reload without commit", 64'(cfg_active[15:0]), 64'h00A5);
    rd_chk("R4 no error when disabled", 4'd2, 16'h0);
  endtask

  task automatic t_mrs_err;
    wr(4'd1, 16'h0001);
    pulse_mrs(1'b0);
    rd_chk("R4 mrs during update", 4'd2, 16'h0001);
    chk("R6 irq follows flag", 64'(err_irq), 64'h1);
    wr(4'd1, 16'h0000);
    chk("R6 irq masked", 64'(err_irq), 64'h0);
    wr(4'd2, 16'h0000);
    rd_chk("R6 write zero keeps flag", 4'd2, 16'h0001);
    wr(4'd2, 16'h0001);
    rd_chk("R6 write one clears", 4'd2, 16'h0000);
    wr(4'd0, 16'h0001);
    wr(4'd1, 16'h0001);
    pulse_mrs(1'b0);
    rd_chk("R4 clean reload no error", 4'd2, 16'h0000);
    chk("R2 second reload", 64'(cfg_active[15:0]), 64'h000F);
  endtask

  task automatic t_ovr;
    wr(4'd1, 16'h0002);
    wr(4'd0, 16'h0008);
    pulse_mrs(1'b0);
    events(8);
    rd_chk("R5 eight events ok", 4'd2, 16'h0000);
    events(1);
    rd_chk("R5 ninth event overrun", 4'd2, 16'h0002);
    chk("R6 overrun irq", 64'(err_irq), 64'h2);
    wr(4'd2, 16'h0002);
    pulse_mrs(1'b1);
    events(7);
    rd_chk("R10 coincident event counted", 4'd2, 16'h0000);
    events(1);
    rd_chk("R10 overrun after coincident", 4'd2, 16'h0002);
    wr(4'd2, 16'h0002);
    wr(4'd0, 16'h0000);
    pulse_mrs(1'b0);
    events(12);
    rd_chk("R5 no overrun outside seq", 4'd2, 16'h0000);
  endtask

  task automatic t_dma;
    wr(4'd1, 16'h0004);
    wr(4'd0, 16'h0001);
    pulse_mrs(1'b0);
    chk("R7 request raised", 64'(dma_req), 64'h1);
    repeat (3) @(negedge clk);
    chk("R7 request held", 64'(dma_req), 64'h1);
    dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
    chk("R7 request dropped", 64'(dma_req), 64'h0);
    pulse_mrs(1'b0);
    chk("R7 no request without reload", 64'(dma_req), 64'h0);
  endtask

  task automatic t_odis;
    wr(4'd0, 16'h0002);
    #1;
    chk("R8 outputs forced low", 64'(trig_out), 64'h0);
    wr(4'd0, 16'h0000);
    #1;
    chk("R8 outputs restored", 64'(trig_out), 64'h0F);
  endtask

  task automatic t_modoff;
    wr(4'd4, 16'h003C);
    wr(4'd0, 16'h0005);
    pulse_mrs(1'b0);
    chk("R9 no reload when off", 64'(cfg_active[15:0]), 64'h000F);
    rd_chk("R9 commit kept", 4'd0, 16'h0005);
    rd_chk("R9 write accepted", 4'd4, 16'h003C);
    wr(4'd0, 16'h0001);
    pulse_mrs(1'b0);
    chk("R9 reload after on", 64'(cfg_active[15:0]), 64'h003C);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_shadow;
    t_reload;
    t_mrs_err;
    t_ovr;
    t_dma;
    t_odis;
    t_modoff;
    repeat (2) @(negedge clk);
    finish_run;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run;
  end
endmodule